// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block briefly takes over a downstream I2C segment and clears any transfer left half-finished on it, before a new controller is joined to that segment. A one-cycle request on `start_i` makes it toggle SCL a fixed number of times while SDA stays released. A slave that was left sending data sees eight data bits followed by a not-acknowledge, so it lets go of SDA. The block then forms a STOP condition and raises a one-cycle `done_o`. The surrounding switch logic uses that pulse to record that initialisation finished and to join the new controller to the segment.

Both lines are open-drain. The block only ever asks for a line to be pulled low, through `scl_oe_o` and `sda_oe_o`. It reads the real line levels back through `scl_i` and `sda_i`, which pass through a synchroniser of `SYNC_STAGES` flops. Each SCL low phase lasts `HALF_CYCLES` system clocks. A high phase only begins to count once the synchronised SCL reads high, so a slave that stretches the clock lengthens the pulse rather than shortening it. The sequence always runs in full, whatever state the bus was in when it was requested.

Top module: `i2c_recovery_seq`

## Requirements
- R1: After reset `scl_oe_o` and `sda_oe_o` are 0 and `busy_o` and `done_o` are 0. Both drive enables stay 0 whenever `busy_o` is 0.
- R2: A `start_i` pulse while idle sets `busy_o` in the next cycle. The block then drives exactly `NUM_PULSES` (default 9) SCL pulses. Each pulse is an SCL low phase of exactly `HALF_CYCLES` clocks (`scl_oe_o`=1) followed by a released high phase.
- R3: `sda_oe_o` stays 0 for the whole of every clock pulse, so SDA is released during all data bits and the acknowledge slot.
- R4: Each SCL high phase lasts `HALF_CYCLES` + `SYNC_STAGES` clocks, counted from the cycle in which the SCL line (`scl_i`) first reads high. A slave holding SCL low lengthens the pulse by the time it holds the line.
- R5: After the last pulse, `sda_oe_o` rises in the same cycle that `scl_oe_o` rises. Both stay 1 for `HALF_CYCLES` clocks. SCL is then released while SDA stays low for `HALF_CYCLES` + `SYNC_STAGES` clocks of SCL high, and then SDA is released with SCL high (the STOP).
- R6: `done_o` is high for exactly one cycle, `HALF_CYCLES` + `SYNC_STAGES` clocks after SDA is released, counted from the first cycle `sda_i` reads high. `busy_o` is already 0 in that cycle and was 1 in every cycle from the one after the start until then.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running sequence keeps its pulse count, only one `done_o` is produced, and no new sequence follows.
- R8: The sequence runs in full even when a slave holds SDA low at the moment of the request.
- R9: If SDA is still held low after the block releases it, `done_o` waits until the line reads high and then follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the recovery sequence |
| busy_o | output | 1 | High while the sequence is running |
| done_o | output | 1 | One-cycle pulse when the sequence has finished |
| scl_oe_o | output | 1 | Pull the downstream SCL line low when 1 |
| sda_oe_o | output | 1 | Pull the downstream SDA line low when 1 |
| scl_i | input | 1 | Level of the downstream SCL line |
| sda_i | input | 1 | Level of the downstream SDA line |

## Verification
The hardest cases are those in which another device holds a line against the sequencer. These are a slave stretching SCL in the middle of a pulse, and SDA held low after the STOP release. In both, the timer must wait on the synchronised line level rather than on its own output. The bench models the bus as a wired-AND of the block's drive and bench-controlled pull-downs. It stretches the third pulse's clock, holds SDA past the STOP release, and in another run plays a slave-transmitter that keeps SDA low until it has seen eight clocks. The scoreboard then expects the same pulse lengths measured from the line level, and a done delay extended by exactly the hold time.

// File: rtl/i2c_recov_pkg.sv
package i2c_recov_pkg;

   typedef enum logic [2:0] {
      RS_IDLE      = 3'd0,
      RS_CLK_LOW   = 3'd1,
      RS_CLK_HIGH  = 3'd2,
      RS_STP_LOW   = 3'd3,
      RS_STP_HIGH  = 3'd4,
      RS_STP_REL   = 3'd5
   } recov_state_t;

   function automatic int unsigned ptr_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/recov_line_sync.sv
module recov_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign line_o = line_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else if (STAGES == 1) begin
               chain_q <= line_i;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], line_i};
            end
         end
         assign line_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/recov_phase_timer.sv
module recov_phase_timer #(
   parameter int unsigned HALF_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic tc_o
);

   localparam int unsigned TW = $clog2(HALF_CYCLES + 1);
   localparam logic [TW-1:0] LAST = TW'(HALF_CYCLES - 1);

   logic [TW-1:0] cnt_q;

   assign tc_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i && !tc_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/recov_pulse_ctr.sv
module recov_pulse_ctr #(
   parameter int unsigned NUM_PULSES = 9,
   parameter int unsigned PW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic          last_o,
   output logic [PW-1:0] idx_o
);

   localparam logic [PW-1:0] FINAL = PW'(NUM_PULSES - 1);

   logic [PW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (inc_i && !last_o) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign last_o = (idx_q == FINAL);
   assign idx_o  = idx_q;

endmodule

// File: rtl/i2c_recovery_seq.sv
module i2c_recovery_seq
   import i2c_recov_pkg::*;
#(
   parameter int unsigned HALF_CYCLES = 4,
   parameter int unsigned NUM_PULSES  = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o,
   output logic scl_oe_o,
   output logic sda_oe_o,
   input  logic scl_i,
   input  logic sda_i
);

   localparam int unsigned PW = ptr_width(NUM_PULSES);

   generate
      if (HALF_CYCLES <= SYNC_STAGES) begin : g_chk_half
         $error("HALF_CYCLES must exceed SYNC_STAGES");
      end
      if (NUM_PULSES < 1) begin : g_chk_pulses
         $error("NUM_PULSES must be at least 1");
      end
   endgenerate

   recov_state_t  state_q, state_d;
   logic          scl_s, sda_s;
   logic          tmr_run, tmr_tc, phase_clr;
   logic          pc_inc, pc_last;
   logic [PW-1:0] pulse_idx;
   logic          done_set, done_q;

   recov_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_s)
   );

   recov_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_s)
   );

   recov_phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr_i(phase_clr), .run_i(tmr_run), .tc_o(tmr_tc)
   );

   recov_pulse_ctr #(.NUM_PULSES(NUM_PULSES), .PW(PW)) u_pulses (
      .clk(clk), .rst_n(rst_n), .clr_i(state_q == RS_IDLE), .inc_i(pc_inc),
      .last_o(pc_last), .idx_o(pulse_idx)
   );

   always_comb begin
      state_d  = state_q;
      tmr_run  = 1'b0;
      pc_inc   = 1'b0;
      done_set = 1'b0;
      unique case (state_q)
         RS_IDLE: begin
            if (start_i) state_d = RS_CLK_LOW;
         end
         RS_CLK_LOW: begin
            tmr_run = 1'b1;
            if (tmr_tc) state_d = RS_CLK_HIGH;
         end
         RS_CLK_HIGH: begin
            tmr_run = scl_s;
            if (tmr_tc) begin
               if (pc_last) begin
                  state_d = RS_STP_LOW;
               end else begin
                  state_d = RS_CLK_LOW;
                  pc_inc  = 1'b1;
               end
            end
         end
         RS_STP_LOW: begin
            tmr_run = 1'b1;
            if (tmr_tc) state_d = RS_STP_HIGH;
         end
         RS_STP_HIGH: begin
            tmr_run = scl_s;
            if (tmr_tc) state_d = RS_STP_REL;
         end
         RS_STP_REL: begin
            tmr_run = sda_s;
            if (tmr_tc) begin
               state_d  = RS_IDLE;
               done_set = 1'b1;
            end
         end
         default: state_d = RS_IDLE;
      endcase
   end

   assign phase_clr = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_set;
      end
   end

   assign busy_o   = (state_q != RS_IDLE);
   assign done_o   = done_q;
   assign scl_oe_o = (state_q == RS_CLK_LOW) || (state_q == RS_STP_LOW);
   assign sda_oe_o = (state_q == RS_STP_LOW) || (state_q == RS_STP_HIGH);

endmodule

// File: rtl/recov_checker.sv
module recov_checker #(
   parameter int unsigned NUM_PULSES = 9,
   parameter int unsigned PW         = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          scl_oe_o,
   input logic          sda_oe_o,
   input logic [PW-1:0] pulse_idx
);

   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_oe_o && !sda_oe_o));

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_idx <= PW'(NUM_PULSES - 1));

   p_sda_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> $rose(scl_oe_o));

   p_stop_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_o) |-> !scl_oe_o);

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o && !scl_oe_o && !sda_oe_o && pulse_idx == '0) |=> !sda_oe_o);

endmodule

bind i2c_recovery_seq recov_checker #(.NUM_PULSES(NUM_PULSES), .PW(PW)) u_recov_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
   .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .pulse_idx(pulse_idx)
);

// File: tb/tb_i2c_recovery_seq.sv
module tb_i2c_recovery_seq;

   localparam int H    = 4;
   localparam int NP   = 9;
   localparam int SY   = 2;
   localparam int K_PULSE = 1;
   localparam int K_STOP  = 2;
   localparam int K_DONE  = 3;

   typedef struct {
      int kind;
      int a;
      int b;
      int c;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic busy_o, done_o, scl_oe_o, sda_oe_o;
   logic scl_block = 1'b0;
   logic sda_block = 1'b0;
   logic slave_hold = 1'b0;
   logic scl_i, sda_i;

   int checks = 0;
   int fails  = 0;
   item_t exp_q[$];

   always #2.5 clk = ~clk;

   assign scl_i = ~scl_oe_o & ~scl_block;
   assign sda_i = ~sda_oe_o & ~sda_block & ~slave_hold;

   i2c_recovery_seq #(.HALF_CYCLES(H), .NUM_PULSES(NP), .SYNC_STAGES(SY)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
      .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .scl_i(scl_i), .sda_i(sda_i)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver side of the scoreboard: one full expected sequence
   task automatic expect_sequence(input int done_extra);
      for (int i = 0; i < NP; i++) exp_q.push_back('{K_PULSE, H, H + SY, 0});
      exp_q.push_back('{K_STOP, H, H + SY, 0});
      exp_q.push_back('{K_DONE, 0, H + SY + done_extra, 0});
   endtask

   task automatic launch();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R2 busy after start", int'(busy_o), 1);
   endtask

   task automatic wait_drain();
      for (int t = 0; t < 2000 && exp_q.size() != 0; t++) @(negedge clk);
      check("R6 all expected items seen", exp_q.size(), 0);
      repeat (4) @(negedge clk);
   endtask

   // monitor side of the scoreboard
   int  low_len = 0, high_len = 0, sda_seen = 0, gap = 0, n_pulse = 0;
   logic prev_scl = 1'b0, prev_sda = 1'b0;

   task automatic compare(input item_t got, input string req);
      item_t e;
      if (exp_q.size() == 0) begin
         checks++;
         fails++;
         $display("FAIL %s unexpected item kind=%0d actual=%0d/%0d expected=none", req, got.kind, got.a, got.b);
         return;
      end
      e = exp_q.pop_front();
      check({req, " kind"}, got.kind, e.kind);
      check({req, " field a"}, got.a, e.a);
      check({req, " field b"}, got.b, e.b);
      check({req, " field c"}, got.c, e.c);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         gap++;
         if (!prev_scl && scl_oe_o) begin
            if (low_len > 0) begin
               compare('{K_PULSE, low_len, high_len, sda_seen}, "R2 R3 R4 pulse");
               n_pulse++;
            end
            low_len = 0; high_len = 0; sda_seen = 0;
         end
         if (prev_sda && !sda_oe_o) begin
            compare('{K_STOP, low_len, high_len, 0}, "R5 stop");
            low_len = 0; high_len = 0; sda_seen = 0; gap = 0;
         end
         if (done_o) compare('{K_DONE, int'(busy_o), gap, 0}, "R6 R9 done");
         if (scl_oe_o) low_len++;
         if (!scl_oe_o && scl_i) high_len++;
         if (sda_oe_o && !(!prev_scl && scl_oe_o)) sda_seen = 1;
         prev_scl = scl_oe_o;
         prev_sda = sda_oe_o;
      end
   end

   // slave-transmitter model: keeps SDA low until it has seen eight clocks
   int   slave_edges = 0;
   logic slave_prev_scl = 1'b1;
   always @(negedge clk) begin
      if (slave_hold) begin
         if (scl_i && !slave_prev_scl) slave_edges++;
         if (slave_edges >= 8) slave_hold = 1'b0;
      end else begin
         slave_edges = 0;
      end
      slave_prev_scl = scl_i;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 scl_oe reset", int'(scl_oe_o), 0);
      check("R1 sda_oe reset", int'(sda_oe_o), 0);
      check("R1 busy reset", int'(busy_o), 0);
      check("R1 done reset", int'(done_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // plain run on an idle bus (R2 R3 R5 R6)
      expect_sequence(0);
      launch();
      wait_drain();

      // R7: a second request in the middle of a run
      expect_sequence(0);
      launch();
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_drain();
      repeat (3 * H) @(negedge clk);
      check("R7 no restart busy", int'(busy_o), 0);
      check("R7 no restart scl", int'(scl_oe_o), 0);

      // R8: stuck slave holding SDA low at request time
      slave_hold = 1'b1;
      @(negedge clk);
      check("R8 sda held before start", int'(sda_i), 0);
      expect_sequence(0);
      launch();
      wait_drain();
      check("R8 slave released", int'(slave_hold), 0);

      // R4: stretch the third pulse
      expect_sequence(0);
      n_pulse = 0;
      launch();
      for (int t = 0; t < 500 && !(n_pulse == 2 && scl_oe_o); t++) @(negedge clk);
      scl_block = 1'b1;
      for (int t = 0; t < 500 && scl_oe_o; t++) @(negedge clk);
      repeat (H + 3) @(negedge clk);
      check("R4 stretch still held", int'(scl_i), 0);
      scl_block = 1'b0;
      wait_drain();

      // R9: SDA kept low after the STOP release
      expect_sequence(5);
      launch();
      for (int t = 0; t < 500 && !sda_oe_o; t++) @(negedge clk);
      sda_block = 1'b1;
      for (int t = 0; t < 500 && sda_oe_o; t++) @(negedge clk);
      repeat (5) @(negedge clk);
      sda_block = 1'b0;
      wait_drain();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule